// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block sits beside an 8-bit CPU core. It picks one interrupt from five flag sources: two external pins, two timer overflow flags and one serial-port flag. It gives the CPU a request line, a three-bit vector index and a two-bit in-service state. Software uses a small register port to program a mask register and a level register. The mask register holds a master enable bit. The level register puts each source at one of two priority levels.

Every source flag passes through one register before arbitration, so a flag seen at a clock edge can first raise the request one clock later. The CPU pulses an accept strobe when it takes the vector, and a return strobe when a service routine ends. A high-level source can interrupt a low-level routine. Nothing can interrupt a high-level routine, and nothing interrupts a routine of its own level. Each external pin works in one of two modes. In level mode the pin is followed directly. In edge mode a falling edge is latched and stays pending until that source is accepted. The timer and serial flags belong to their own blocks and are only sampled here. The controller never clears them.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset both registers read 0x00, irq is 0 and in_svc is 2'b00.
- R2: With reg_sel=0 the mask register is addressed: bit 7 is the master enable and bits 4..0 enable the sources, with source k at bit k. Bits 6..5 always read 0 and ignore writes. With reg_sel=1 the level register is addressed: bit k set puts source k at the high level, and bits 7..5 read 0. Writes take effect at the clock edge on which reg_wr is 1.
- R3: While the master enable is 0, irq stays 0 whatever the source enables and flags are.
- R4: A source flag present at a clock edge can raise irq from the next cycle on. A flag removed at an edge stops requesting from the next cycle on.
- R5: The vector index codes are: 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial. Among enabled pending sources of the same level, the lowest index is presented.
- R6: With nothing in service, any enabled pending high-level source is presented ahead of every low-level source.
- R7: While a low-level routine is in service, only high-level sources raise irq. While a high-level routine is in service, irq is 0.
- R8: An accept strobe while irq is 1 sets in_svc[1] if the presented source is high-level, or in_svc[0] if it is low-level. A return strobe clears in_svc[1] if it is set, and clears in_svc[0] otherwise.
- R9: External pins are active low. In edge mode (ext_edge=1) a high-to-low transition latches a pending flag. The flag survives the pin returning high and is cleared when that vector is accepted. A new edge in the same cycle as the accept wins. In level mode the request follows the pin and is never cleared by accept.
- R10: The serial source is the OR of ser_tx and ser_rx. Accepting it does not clear it, so it requests again once its level is free.
- R11: An accept strobe while irq is 0 is ignored and leaves in_svc unchanged.
- R12: An accept and a return in the same cycle both take effect: the return releases the level in service and the accept marks the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register select: 0 mask, 1 level |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_n | input | 2 | External interrupt pins, active low |
| ext_edge | input | 2 | Per pin: 1 edge mode, 0 level mode |
| tmr_ovf | input | 2 | Timer overflow flags |
| ser_tx | input | 1 | Serial transmit-done flag |
| ser_rx | input | 1 | Serial receive-done flag |
| ack | input | 1 | CPU accepts the presented vector |
| ret | input | 1 | CPU ends the current service routine |
| irq | output | 1 | Interrupt request to the CPU |
| vec | output | 3 | Vector index of the presented source |
| in_svc | output | 2 | In-service state: bit 1 high level, bit 0 low level |

## Verification
Two events can land on the same clock edge, and each case is provoked on purpose. In the first, an accept that takes a high-level vector arrives together with the return that closes the low-level routine. The expected result is in_svc equal to 2'b10. In the second, an edge-mode pin falls again in the very cycle its earlier edge is accepted, and the flag must survive. Directed cases set up both collisions deliberately. A long randomized run of strobes, pins and register writes then hits them again, and a behavioural reference model judges every cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  parameter int unsigned DW      = 8;
  parameter int unsigned NEXT    = 2;
  parameter int unsigned NTMR    = 2;
  parameter int unsigned NSRC    = NEXT + NTMR + 1;
  parameter int unsigned VW      = $clog2(NSRC);
  parameter int unsigned GIE_BIT = DW - 1;
  parameter logic        SEL_EN  = 1'b0;
  parameter logic        SEL_PRI = 1'b1;

  // lowest set index wins (fixed polling order)
  function automatic logic [VW-1:0] first_set(input logic [NSRC-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = VW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            gie,
  output logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] src_pri
);
  localparam int unsigned GAP = DW - 1 - NSRC;

  logic            gie_q, gie_d;
  logic [NSRC-1:0] en_q, en_d, pri_q, pri_d;
  logic            en_we, pri_we;

  assign en_we  = wr & (sel == SEL_EN);
  assign pri_we = wr & (sel == SEL_PRI);

  always_comb begin
    gie_d = gie_q;
    en_d  = en_q;
    pri_d = pri_q;
    if (en_we) begin
      gie_d = wdata[GIE_BIT];
      en_d  = wdata[NSRC-1:0];
    end
    if (pri_we) begin
      pri_d = wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      gie_q <= gie_d;
      en_q  <= en_d;
      pri_q <= pri_d;
    end
  end

  assign rdata   = (sel == SEL_PRI) ? {{(DW-NSRC){1'b0}}, pri_q}
                                    : {gie_q, {GAP{1'b0}}, en_q};
  assign gie     = gie_q;
  assign src_en  = en_q;
  assign src_pri = pri_q;
endmodule

// File: rtl/pirq_capture.sv
module pirq_capture
  import pirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_n,
  input  logic [NEXT-1:0] ext_edge,
  input  logic [NEXT-1:0] ext_clr,
  input  logic [NTMR-1:0] tmr_ovf,
  input  logic            ser_flag,
  output logic [NSRC-1:0] pend
);
  logic [NEXT-1:0] prev_q, flag_q, flag_d;
  logic [NTMR-1:0] tmr_q;
  logic            ser_q;

  // edge mode latches a falling edge until accepted; level mode follows the pin
  always_comb begin
    for (int i = 0; i < NEXT; i++) begin
      if (ext_edge[i]) begin
        flag_d[i] = (prev_q[i] & ~ext_n[i]) | (flag_q[i] & ~ext_clr[i]);
      end else begin
        flag_d[i] = ~ext_n[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      flag_q <= '0;
      tmr_q  <= '0;
      ser_q  <= 1'b0;
    end else begin
      prev_q <= ext_n;
      flag_q <= flag_d;
      tmr_q  <= tmr_ovf;
      ser_q  <= ser_flag;
    end
  end

  // interleave external and timer flags in polling order, serial last
  for (genvar g = 0; g < NEXT; g++) begin : g_map
    assign pend[2*g]   = flag_q[g];
    assign pend[2*g+1] = tmr_q[g];
  end
  assign pend[NSRC-1] = ser_q;
endmodule

// File: rtl/pirq_select.sv
module pirq_select
  import pirq_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_pri,
  input  logic            gie,
  input  logic            svc_hi,
  input  logic            svc_lo,
  output logic            req,
  output logic [VW-1:0]   idx,
  output logic            lvl_hi
);
  logic [NSRC-1:0] act, act_hi, act_lo;

  assign act    = pend & src_en & {NSRC{gie}};
  assign act_hi = act & src_pri;
  assign act_lo = act & ~src_pri;

  always_comb begin
    req    = 1'b0;
    idx    = '0;
    lvl_hi = 1'b0;
    if ((|act_hi) && !svc_hi) begin
      req    = 1'b1;
      idx    = first_set(act_hi);
      lvl_hi = 1'b1;
    end else if ((|act_lo) && !svc_hi && !svc_lo) begin
      req = 1'b1;
      idx = first_set(act_lo);
    end
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_sel,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NEXT-1:0] ext_n,
  input  logic [NEXT-1:0] ext_edge,
  input  logic [NTMR-1:0] tmr_ovf,
  input  logic            ser_tx,
  input  logic            ser_rx,
  input  logic            ack,
  input  logic            ret,
  output logic            irq,
  output logic [VW-1:0]   vec,
  output logic [1:0]      in_svc
);
  logic            rst_s1_q, rst_ni;
  logic            gie;
  logic [NSRC-1:0] src_en, src_pri, pend;
  logic [NEXT-1:0] ext_clr;
  logic            req, lvl_hi, take;
  logic [VW-1:0]   idx;
  logic            svc_hi_q, svc_hi_d, svc_lo_q, svc_lo_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_ni   <= rst_s1_q;
    end
  end

  pirq_regs u_regs (
    .clk(clk), .rst_n(rst_ni), .sel(reg_sel), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .gie(gie), .src_en(src_en), .src_pri(src_pri)
  );

  pirq_capture u_cap (
    .clk(clk), .rst_n(rst_ni), .ext_n(ext_n), .ext_edge(ext_edge),
    .ext_clr(ext_clr), .tmr_ovf(tmr_ovf), .ser_flag(ser_tx | ser_rx), .pend(pend)
  );

  pirq_select u_sel (
    .pend(pend), .src_en(src_en), .src_pri(src_pri), .gie(gie),
    .svc_hi(svc_hi_q), .svc_lo(svc_lo_q), .req(req), .idx(idx), .lvl_hi(lvl_hi)
  );

  assign take = ack & req;

  for (genvar g = 0; g < NEXT; g++) begin : g_clr
    assign ext_clr[g] = take & (idx == VW'(2*g)) & ext_edge[g];
  end

  // return releases the highest level first; accept then marks the new level
  always_comb begin
    svc_hi_d = svc_hi_q;
    svc_lo_d = svc_lo_q;
    if (ret) begin
      if (svc_hi_q) svc_hi_d = 1'b0;
      else          svc_lo_d = 1'b0;
    end
    if (take) begin
      if (lvl_hi) svc_hi_d = 1'b1;
      else        svc_lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_hi_q <= 1'b0;
      svc_lo_q <= 1'b0;
    end else begin
      svc_hi_q <= svc_hi_d;
      svc_lo_q <= svc_lo_d;
    end
  end

  assign irq    = req;
  assign vec    = idx;
  assign in_svc = {svc_hi_q, svc_lo_q};
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk
  import pirq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          gie,
  input logic          ack,
  input logic          ret,
  input logic          irq,
  input logic [VW-1:0] vec,
  input logic [1:0]    in_svc
);
  p_gie_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);

  p_vec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec <= VW'(NSRC - 1)));

  p_hi_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc[1] |-> !irq);

  p_accept_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (in_svc != 2'b00));

  p_return_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack && in_svc[1]) |=> (!in_svc[1] && (in_svc[0] == $past(in_svc[0]))));

  p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !ret) |=> $stable(in_svc));
endmodule

bind pirq_ctrl pirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .ack(ack), .ret(ret),
  .irq(irq), .vec(vec), .in_svc(in_svc)
);

// File: tb/sim_pirq_ctrl.sv
module sim_pirq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] ext_n = 2'b11;
  logic [1:0] ext_edge = 2'b00;
  logic [1:0] tmr_ovf = 2'b00;
  logic       ser_tx = 1'b0;
  logic       ser_rx = 1'b0;
  logic       ack = 1'b0;
  logic       ret = 1'b0;
  logic       irq;
  logic [2:0] vec;
  logic [1:0] in_svc;

  always #10 clk = ~clk;

  pirq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_n(ext_n),
    .ext_edge(ext_edge), .tmr_ovf(tmr_ovf), .ser_tx(ser_tx), .ser_rx(ser_rx),
    .ack(ack), .ret(ret), .irq(irq), .vec(vec), .in_svc(in_svc)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    wd = 0;
  string tag = "R1";

  // behavioural reference state
  bit       m_gie;
  bit [4:0] m_en, m_pri, m_pend;
  bit [1:0] m_prev = 2'b11;
  bit       m_shi, m_slo;
  int       m_rcnt = 0;

  function automatic void m_pick(output bit r, output int idx, output bit hi);
    r = 0; idx = 0; hi = 0;
    for (int lv = 1; lv >= 0; lv--) begin
      bit blocked;
      blocked = (lv == 1) ? m_shi : (m_shi || m_slo);
      for (int i = 0; i < 5; i++) begin
        if (!r && !blocked && m_gie && m_en[i] && m_pend[i] && (int'(m_pri[i]) == lv)) begin
          r = 1; idx = i; hi = (lv == 1);
        end
      end
    end
  endfunction

  function automatic bit [7:0] m_rdata(input bit s);
    return s ? {3'b000, m_pri} : {m_gie, 2'b00, m_en};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gie = 0; m_en = 0; m_pri = 0; m_pend = 0; m_prev = 2'b11;
      m_shi = 0; m_slo = 0; m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      bit r, hi, take;
      int idx;
      bit [4:0] np;
      m_pick(r, idx, hi);
      take = ack && r;
      if (ret) begin
        if (m_shi) m_shi = 0;
        else       m_slo = 0;
      end
      if (take) begin
        if (hi) m_shi = 1;
        else    m_slo = 1;
      end
      np = m_pend;
      for (int e = 0; e < 2; e++) begin
        bit fallv, clr;
        fallv = m_prev[e] && !ext_n[e];
        clr   = take && (idx == 2 * e);
        np[2*e] = ext_edge[e] ? (fallv || (m_pend[2*e] && !clr)) : !ext_n[e];
      end
      np[1] = tmr_ovf[0];
      np[3] = tmr_ovf[1];
      np[4] = ser_tx || ser_rx;
      m_pend = np;
      m_prev = ext_n;
      if (reg_wr) begin
        if (!reg_sel) begin m_gie = reg_wdata[7]; m_en = reg_wdata[4:0]; end
        else          m_pri = reg_wdata[4:0];
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit r, hi, ok;
    int idx;
    m_pick(r, idx, hi);
    ok = (irq == r) && (!r || (int'(vec) == idx)) &&
         (in_svc == {m_shi, m_slo}) && (reg_rdata == m_rdata(reg_sel));
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s t=%0t: irq=%0b vec=%0d svc=%b rd=%h expected irq=%0b vec=%0d svc=%b rd=%h",
               tag, $time, irq, vec, in_svc, reg_rdata, r, idx, {m_shi, m_slo}, m_rdata(reg_sel));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL %s watchdog expired: actual hung expected finished", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tg, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tg, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wreg(input logic s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rchk(input logic s, input int exp, input string tg);
    reg_sel = s;
    @(negedge clk);
    chk(tg, int'(reg_rdata), exp);
    tick();
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) tick();

    tag = "R1";
    rchk(1'b0, 0, "R1 mask reset");
    rchk(1'b1, 0, "R1 level reset");
    @(negedge clk);
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 in_svc reset", int'(in_svc), 0);
    tick();

    tag = "R2";
    wreg(1'b0, 8'hFF);
    rchk(1'b0, 8'h9F, "R2 mask reserved bits");
    wreg(1'b1, 8'hFF);
    rchk(1'b1, 8'h1F, "R2 level upper bits");
    wreg(1'b0, 8'h00);
    wreg(1'b1, 8'h00);

    tag = "R3";
    wreg(1'b0, 8'h1F);
    ext_n = 2'b00; tmr_ovf = 2'b11; ser_rx = 1'b1;
    repeat (3) tick();
    @(negedge clk);
    chk("R3 master enable off", int'(irq), 0);
    tick();
    ext_n = 2'b11; tmr_ovf = 2'b00; ser_rx = 1'b0;
    repeat (2) tick();

    tag = "R4";
    wreg(1'b0, 8'h82);
    tmr_ovf[0] = 1'b1;
    @(negedge clk);
    chk("R4 not yet sampled", int'(irq), 0);
    tick();
    @(negedge clk);
    chk("R4 one cycle later", int'(irq), 1);
    chk("R4 vector", int'(vec), 1);
    tick();
    tmr_ovf = 2'b00;
    tick();
    @(negedge clk);
    chk("R4 removal", int'(irq), 0);
    tick();

    tag = "R5";
    wreg(1'b0, 8'h9F);
    wreg(1'b1, 8'h00);
    ext_n = 2'b01; tmr_ovf = 2'b01; ser_tx = 1'b1;
    tick();
    @(negedge clk);
    chk("R5 timer0 first", int'(vec), 1);
    tick();
    tmr_ovf = 2'b00;
    tick();
    @(negedge clk);
    chk("R5 ext1 next", int'(vec), 2);
    tick();
    ext_n = 2'b11;
    tick();
    @(negedge clk);
    chk("R5 serial last", int'(vec), 4);
    tick();
    ser_tx = 1'b0;
    tick();

    tag = "R6";
    wreg(1'b1, 8'h10);
    ext_n = 2'b10; ser_rx = 1'b1;
    tick();
    @(negedge clk);
    chk("R6 high level first", int'(vec), 4);
    tick();

    tag = "R7";
    ser_rx = 1'b0;
    repeat (2) tick();
    pulse_ack();
    @(negedge clk);
    chk("R8 low level marked", int'(in_svc), 1);
    chk("R7 low blocks low", int'(irq), 0);
    tick();
    ser_rx = 1'b1;
    tick();
    @(negedge clk);
    chk("R7 high preempts low", int'(irq), 1);
    chk("R7 high vector", int'(vec), 4);
    tick();
    pulse_ack();
    @(negedge clk);
    chk("R8 both levels marked", int'(in_svc), 3);
    chk("R7 high blocks all", int'(irq), 0);
    tick();
    tag = "R8";
    ret = 1'b1;
    tick();
    ret = 1'b0;
    @(negedge clk);
    chk("R8 return clears high", int'(in_svc), 1);
    tick();
    ser_rx = 1'b0; ret = 1'b1;
    tick();
    ret = 1'b0;
    @(negedge clk);
    chk("R8 return clears low", int'(in_svc), 0);
    tick();
    ext_n = 2'b11;
    repeat (2) tick();

    tag = "R9";
    wreg(1'b1, 8'h00);
    ext_edge = 2'b01; ext_n = 2'b10;
    tick();
    ext_n = 2'b11;
    tick();
    @(negedge clk);
    chk("R9 edge latched", int'(irq), 1);
    chk("R9 edge vector", int'(vec), 0);
    tick();
    pulse_ack();
    ret = 1'b1;
    tick();
    ret = 1'b0;
    @(negedge clk);
    chk("R9 edge flag cleared by accept", int'(irq), 0);
    chk("R9 service closed", int'(in_svc), 0);
    tick();
    ext_edge = 2'b00; ext_n = 2'b10;
    repeat (2) tick();
    pulse_ack();
    ret = 1'b1;
    tick();
    ret = 1'b0;
    @(negedge clk);
    chk("R9 level not cleared", int'(irq), 1);
    tick();
    ext_n = 2'b11;
    repeat (2) tick();

    tag = "R10";
    ser_tx = 1'b1;
    repeat (2) tick();
    @(negedge clk);
    chk("R10 serial from tx", int'(vec), 4);
    tick();
    pulse_ack();
    ret = 1'b1;
    tick();
    ret = 1'b0;
    @(negedge clk);
    chk("R10 serial still pending", int'(irq), 1);
    chk("R10 serial vector", int'(vec), 4);
    tick();
    ser_tx = 1'b0;
    repeat (2) tick();

    tag = "R11";
    ack = 1'b1;
    tick();
    ack = 1'b0;
    @(negedge clk);
    chk("R11 idle accept ignored", int'(in_svc), 0);
    chk("R11 no request", int'(irq), 0);
    tick();

    tag = "R12";
    wreg(1'b1, 8'h08);
    ext_n = 2'b10;
    repeat (2) tick();
    pulse_ack();
    tmr_ovf[1] = 1'b1;
    repeat (2) tick();
    @(negedge clk);
    chk("R12 high request", int'(vec), 3);
    tick();
    ack = 1'b1; ret = 1'b1;
    tick();
    ack = 1'b0; ret = 1'b0;
    @(negedge clk);
    chk("R12 accept and return together", int'(in_svc), 2);
    tick();
    tmr_ovf = 2'b00; ext_n = 2'b11; ret = 1'b1;
    tick();
    ret = 1'b0;
    repeat (2) tick();

    tag = "R5,R7,R9,R12";
    for (int k = 0; k < 4000; k++) begin
      ext_n    = 2'($urandom_range(0, 3) | (($urandom_range(0, 3) == 0) ? 0 : 3));
      ext_edge = (k % 500 == 0) ? 2'($urandom_range(0, 3)) : ext_edge;
      tmr_ovf  = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      ser_tx   = ($urandom_range(0, 7) == 0);
      ser_rx   = ($urandom_range(0, 7) == 0);
      ack      = ($urandom_range(0, 2) == 0);
      ret      = ($urandom_range(0, 3) == 0);
      reg_wr   = ($urandom_range(0, 15) == 0);
      reg_sel  = 1'($urandom_range(0, 1));
      reg_wdata = 8'($urandom_range(0, 255)) | ((k % 3 == 0) ? 8'h80 : 8'h00);
      tick();
    end
    ack = 1'b0; ret = 1'b0; reg_wr = 1'b0;
    repeat (3) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule